// File: doc/BRIEF.md
# Shadowed PWM Compare Unit

This block is the compare stage of one PWM channel that drives a pair of outputs. Every clock it compares an external 16-bit time-base count with the active compare value. When the two are equal it raises a one-clock compare event. Two independent action qualifiers turn that event into an action on output A and on output B: leave, force low, force high or invert. The time base itself is outside the block and supplies its count together with two flags that mark the count at zero and the count at period.

Software reaches the compare value through one 32-bit read/write word. The upper half holds the compare value and bits 15:8 hold a high-resolution extension byte. A mode input selects how that word is reached:
- In buffered mode, writes land in a shadow copy, and a selectable counter event later moves the shadow copy into the active copy. A full flag shows that a written value is still waiting to be moved.
- In direct mode, writes go straight to the active copy.

In both modes the word sits at the same place, and a read returns the copy that a write would reach.

Top module: `pwm_cmp_unit`

## Requirements
- R1: After a synchronous reset, both copies of the compare value and extension, the full flag, read data, the compare event and both outputs are 0.
- R2: `cmp_event` is 1 for exactly the clocks that follow a clock edge at which `tb_count` equalled the active compare value.
- R3: Each output applies its 2-bit action at the same edge that raises `cmp_event`. The action codes are 00 leave, 01 drive low, 10 drive high, 11 invert. With no match, the output holds its value.
- R4: Output A follows `act_a` and output B follows `act_b`, independently of each other, for the same compare event.
- R5: With `direct_mode`=0, a write stores into the shadow copy. The active copy, and with it the event timing, stays unchanged until a load.
- R6: With `direct_mode`=0, `load_sel` picks the load trigger: 00 is `tb_at_zero`, 01 is `tb_at_period`, 10 is either flag, and 11 means no load. On a trigger, the active copy takes the shadow copy held before that edge.
- R7: `shadow_full` becomes 1 after a buffered write and becomes 0 after the edge at which a load happens. If a buffered write and a load fall on the same edge, the flag stays 1 and the shadow copy keeps the new data.
- R8: With `direct_mode`=1, a write updates the active copy, and that copy is compared from the next clock onwards. The written value produces no event for the count present in the write cycle.
- R9: Word layout: bits 31:16 hold the compare value and bits 15:8 hold the extension. Bits 7:0 are not stored and read back as 0. The extension follows the same shadow and active path as the compare value.
- R10: `rd_data` is registered. After each edge it shows the shadow copy if `direct_mode` was 0 at that edge, or the active copy if it was 1, as both copies stood before that edge.
- R11: With `direct_mode`=1, no load happens, and the shadow copy and `shadow_full` keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tb_count | input | 16 | Time-base count |
| tb_at_zero | input | 1 | Count is at zero this cycle |
| tb_at_period | input | 1 | Count is at period this cycle |
| direct_mode | input | 1 | 0 buffered (shadow) access, 1 direct access to the active copy |
| load_sel | input | 2 | Shadow load trigger select |
| act_a | input | 2 | Action for output A on a compare event |
| act_b | input | 2 | Action for output B on a compare event |
| wr_en | input | 1 | Write strobe for the compare word |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Registered read data |
| shadow_full | output | 1 | A buffered value waits for load |
| cmp_event | output | 1 | Registered compare event pulse |
| pwm_a | output | 1 | Output A |
| pwm_b | output | 1 | Output B |

## Verification
Every result of this block is due exactly one clock after the edge that samples its stimulus:
- the compare event and both outputs follow the count and the active copy present at that edge;
- the read word, the full flag and a newly loaded or written active copy appear after that same edge.

A loaded or written value therefore first affects comparisons one clock after its write or load edge. The bench drives inputs at the falling edge. It steps a behavioural model with the inputs that the following rising edge samples, and compares all five results at the next falling edge. This puts each check one register stage after its cause. The stimulus places writes on the same edge as a load trigger, and writes direct values equal to the count of the write cycle, so that both corner cases are hit on the exact edge.

// File: rtl/pwm_cmp_pkg.sv
package pwm_cmp_pkg;

  typedef enum logic [1:0] {
    ACT_KEEP   = 2'b00,
    ACT_LOW    = 2'b01,
    ACT_HIGH   = 2'b10,
    ACT_INVERT = 2'b11
  } act_e;

  typedef enum logic [1:0] {
    LD_ON_ZERO   = 2'b00,
    LD_ON_PERIOD = 2'b01,
    LD_ON_EITHER = 2'b10,
    LD_NONE      = 2'b11
  } ld_e;

endpackage

// File: rtl/cmp_regfile.sv
module cmp_regfile #(
  parameter int CMP_W = 16,
  parameter int HR_W  = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               direct_mode,
  input  logic [1:0]         load_sel,
  input  logic               at_zero,
  input  logic               at_period,
  input  logic               wr_en,
  input  logic [2*CMP_W-1:0] wr_data,
  output logic [CMP_W-1:0]   act_cmp,
  output logic [2*CMP_W-1:0] rd_data,
  output logic               shadow_full
);
  import pwm_cmp_pkg::*;

  localparam int DW     = 2 * CMP_W;
  localparam int HR_LSB = CMP_W - HR_W;

  logic [CMP_W-1:0] sh_cmp_q;
  logic [HR_W-1:0]  sh_hr_q, act_hr_q;
  logic [CMP_W-1:0] act_cmp_q;
  logic             full_q;
  logic [DW-1:0]    rd_q;
  logic             load_hit;
  logic [CMP_W-1:0] w_cmp;
  logic [HR_W-1:0]  w_hr;

  assign w_cmp = wr_data[DW-1:CMP_W];
  assign w_hr  = wr_data[CMP_W-1:HR_LSB];

  always_comb begin
    case (ld_e'(load_sel))
      LD_ON_ZERO:   load_hit = at_zero;
      LD_ON_PERIOD: load_hit = at_period;
      LD_ON_EITHER: load_hit = at_zero | at_period;
      default:      load_hit = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_cmp_q  <= '0;
      sh_hr_q   <= '0;
      act_cmp_q <= '0;
      act_hr_q  <= '0;
      full_q    <= 1'b0;
      rd_q      <= '0;
    end else begin
      if (direct_mode)
        rd_q <= {act_cmp_q, act_hr_q, {HR_LSB{1'b0}}};
      else
        rd_q <= {sh_cmp_q, sh_hr_q, {HR_LSB{1'b0}}};
      if (!direct_mode) begin
        if (load_hit) begin
          act_cmp_q <= sh_cmp_q;
          act_hr_q  <= sh_hr_q;
        end
        if (wr_en) begin
          sh_cmp_q <= w_cmp;
          sh_hr_q  <= w_hr;
          full_q   <= 1'b1;
        end else if (load_hit) begin
          full_q   <= 1'b0;
        end
      end else if (wr_en) begin
        act_cmp_q <= w_cmp;
        act_hr_q  <= w_hr;
      end
    end
  end

  assign act_cmp     = act_cmp_q;
  assign rd_data     = rd_q;
  assign shadow_full = full_q;

  // R7: a buffered write always leaves the flag set
  a_r7_full_set: assert property (@(posedge clk) disable iff (rst)
    (!direct_mode && wr_en) |=> shadow_full);
  // R7: a load without a concurrent write empties the shadow
  a_r7_full_clear: assert property (@(posedge clk) disable iff (rst)
    (!direct_mode && !wr_en && load_hit) |=> !shadow_full);
  // R8: a direct write reaches the compared value one clock later
  a_r8_direct_write: assert property (@(posedge clk) disable iff (rst)
    (direct_mode && wr_en) |=> (act_cmp == $past(wr_data[DW-1:CMP_W])));
  // R11: direct mode never touches the full flag
  a_r11_full_hold: assert property (@(posedge clk) disable iff (rst)
    direct_mode |=> $stable(shadow_full));
  // R5: without a load the active copy ignores buffered writes
  a_r5_no_early_load: assert property (@(posedge clk) disable iff (rst)
    (!direct_mode && !load_hit) |=> $stable(act_cmp));

endmodule

// File: rtl/cmp_match.sv
module cmp_match #(
  parameter int CMP_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CMP_W-1:0] count,
  input  logic [CMP_W-1:0] act_cmp,
  output logic             hit,
  output logic             event_q
);
  assign hit = (count == act_cmp);

  always_ff @(posedge clk) begin
    if (rst) event_q <= 1'b0;
    else     event_q <= hit;
  end

  // R2: a count unequal to the compared value gives no event
  a_r2_no_false_event: assert property (@(posedge clk) disable iff (rst)
    (count != act_cmp) |=> !event_q);
endmodule

// File: rtl/cmp_qualifier.sv
module cmp_qualifier (
  input  logic       clk,
  input  logic       rst,
  input  logic       hit,
  input  logic [1:0] action,
  output logic       pin
);
  import pwm_cmp_pkg::*;

  logic pin_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_q <= 1'b0;
    end else if (hit) begin
      case (act_e'(action))
        ACT_LOW:    pin_q <= 1'b0;
        ACT_HIGH:   pin_q <= 1'b1;
        ACT_INVERT: pin_q <= ~pin_q;
        default:    pin_q <= pin_q;
      endcase
    end
  end

  assign pin = pin_q;

  // R3: the four action codes
  a_r3_drive_high: assert property (@(posedge clk) disable iff (rst)
    (hit && action == 2'b10) |=> pin);
  a_r3_drive_low: assert property (@(posedge clk) disable iff (rst)
    (hit && action == 2'b01) |=> !pin);
  a_r3_invert: assert property (@(posedge clk) disable iff (rst)
    (hit && action == 2'b11) |=> (pin != $past(pin)));
  a_r3_hold: assert property (@(posedge clk) disable iff (rst)
    (!hit || action == 2'b00) |=> $stable(pin));
endmodule

// File: rtl/pwm_cmp_unit.sv
module pwm_cmp_unit #(
  parameter int CMP_W = 16,
  parameter int HR_W  = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [CMP_W-1:0]   tb_count,
  input  logic               tb_at_zero,
  input  logic               tb_at_period,
  input  logic               direct_mode,
  input  logic [1:0]         load_sel,
  input  logic [1:0]         act_a,
  input  logic [1:0]         act_b,
  input  logic               wr_en,
  input  logic [2*CMP_W-1:0] wr_data,
  output logic [2*CMP_W-1:0] rd_data,
  output logic               shadow_full,
  output logic               cmp_event,
  output logic               pwm_a,
  output logic               pwm_b
);
  localparam int N_OUT = 2;

  logic [CMP_W-1:0] act_cmp;
  logic             hit;
  logic [1:0]       act_sel [N_OUT];
  logic [N_OUT-1:0] pins;

  assign act_sel[0] = act_a;
  assign act_sel[1] = act_b;

  cmp_regfile #(.CMP_W(CMP_W), .HR_W(HR_W)) u_regs (
    .clk(clk), .rst(rst), .direct_mode(direct_mode), .load_sel(load_sel),
    .at_zero(tb_at_zero), .at_period(tb_at_period), .wr_en(wr_en),
    .wr_data(wr_data), .act_cmp(act_cmp), .rd_data(rd_data),
    .shadow_full(shadow_full)
  );

  cmp_match #(.CMP_W(CMP_W)) u_match (
    .clk(clk), .rst(rst), .count(tb_count), .act_cmp(act_cmp),
    .hit(hit), .event_q(cmp_event)
  );

  for (genvar g = 0; g < N_OUT; g++) begin : g_qual
    cmp_qualifier u_qual (
      .clk(clk), .rst(rst), .hit(hit), .action(act_sel[g]), .pin(pins[g])
    );
  end

  assign pwm_a = pins[0];
  assign pwm_b = pins[1];
endmodule

// File: tb/pwm_cmp_unit_tb.sv
module pwm_cmp_unit_tb;
  localparam int PRD = 9;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] tb_count = '0;
  logic        tb_at_zero = 1'b1, tb_at_period = 1'b0;
  logic        direct_mode = 1'b0;
  logic [1:0]  load_sel = 2'b11, act_a = 2'b00, act_b = 2'b00;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        shadow_full, cmp_event, pwm_a, pwm_b;

  always #4 clk = ~clk;

  pwm_cmp_unit u_dut (
    .clk(clk), .rst(rst), .tb_count(tb_count), .tb_at_zero(tb_at_zero),
    .tb_at_period(tb_at_period), .direct_mode(direct_mode),
    .load_sel(load_sel), .act_a(act_a), .act_b(act_b), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .shadow_full(shadow_full),
    .cmp_event(cmp_event), .pwm_a(pwm_a), .pwm_b(pwm_b)
  );

  int checks = 0, errors = 0;
  bit done = 0;
  string phase = "R1 reset";

  // behavioural model state
  int m_sh_cmp, m_sh_hr, m_ac_cmp, m_ac_hr;
  bit m_full, m_evt, m_a, m_b;
  logic [31:0] m_rd;

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s [%s] actual=%h expected=%h at %0t", tag, phase, got, exp, $time);
    end
  endtask

  function automatic bit apply(bit cur, logic [1:0] a);
    case (a)
      2'b01: return 1'b0;
      2'b10: return 1'b1;
      2'b11: return ~cur;
      default: return cur;
    endcase
  endfunction

  task automatic model_step();
    bit match, ld;
    if (rst) begin
      m_sh_cmp = 0; m_sh_hr = 0; m_ac_cmp = 0; m_ac_hr = 0;
      m_full = 0; m_evt = 0; m_a = 0; m_b = 0; m_rd = '0;
      return;
    end
    m_rd = direct_mode ? {m_ac_cmp[15:0], m_ac_hr[7:0], 8'h00}
                       : {m_sh_cmp[15:0], m_sh_hr[7:0], 8'h00};
    match = (int'(tb_count) == m_ac_cmp);
    m_evt = match;
    if (match) begin
      m_a = apply(m_a, act_a);
      m_b = apply(m_b, act_b);
    end
    case (load_sel)
      2'b00: ld = tb_at_zero;
      2'b01: ld = tb_at_period;
      2'b10: ld = tb_at_zero || tb_at_period;
      default: ld = 0;
    endcase
    if (!direct_mode) begin
      if (ld) begin m_ac_cmp = m_sh_cmp; m_ac_hr = m_sh_hr; end
      if (wr_en) begin
        m_sh_cmp = int'(wr_data[31:16]); m_sh_hr = int'(wr_data[15:8]); m_full = 1;
      end else if (ld) m_full = 0;
    end else if (wr_en) begin
      m_ac_cmp = int'(wr_data[31:16]); m_ac_hr = int'(wr_data[15:8]);
    end
  endtask

  // one clock: edge samples the current inputs, then check and advance
  task automatic step();
    @(posedge clk);
    @(negedge clk);
    model_step();
    check("R2", {31'b0, cmp_event}, {31'b0, m_evt});
    check("R3", {31'b0, pwm_a}, {31'b0, m_a});
    check("R4", {31'b0, pwm_b}, {31'b0, m_b});
    check("R7", {31'b0, shadow_full}, {31'b0, m_full});
    check("R10", rd_data, m_rd);
    wr_en = 1'b0;
    tb_count = (tb_count == 16'(PRD)) ? 16'd0 : tb_count + 16'd1;
    tb_at_zero = (tb_count == 16'd0);
    tb_at_period = (tb_count == 16'(PRD));
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic wait_count(int v);
    while (int'(tb_count) != v) step();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    run(3);
    rst = 1'b0;
    phase = "R1 state after reset";
    run(2);
    phase = "R5 R9 buffered write, no load";
    act_a = 2'b11; act_b = 2'b10;
    wr_en = 1'b1; wr_data = 32'h0005_ABCD;
    run(2 * (PRD + 1));
    phase = "R6 load on zero";
    load_sel = 2'b00;
    run(2 * (PRD + 1));
    phase = "R6 load on period";
    load_sel = 2'b01; act_a = 2'b10; act_b = 2'b01;
    wr_en = 1'b1; wr_data = 32'h0003_5A77;
    run(2 * (PRD + 1));
    phase = "R6 load on either";
    load_sel = 2'b10; act_a = 2'b01; act_b = 2'b11;
    wr_en = 1'b1; wr_data = 32'h0007_1200;
    run(2 * (PRD + 1));
    phase = "R7 write on load edge";
    load_sel = 2'b00;
    wait_count(0);
    wr_en = 1'b1; wr_data = 32'h0002_C3FF;
    run(PRD + 3);
    phase = "R4 independent outputs";
    act_a = 2'b11; act_b = 2'b00;
    run(2 * (PRD + 1));
    phase = "R8 R11 direct write";
    direct_mode = 1'b1;
    wr_en = 1'b1; wr_data = 32'h0008_6600;
    run(3);
    wr_en = 1'b1; wr_data = {tb_count, 16'h9911};
    run(2 * (PRD + 1));
    phase = "R11 direct mode ignores load triggers";
    load_sel = 2'b10;
    run(PRD + 2);
    phase = "R10 R9 readback after mode return";
    direct_mode = 1'b0;
    run(PRD + 3);
    phase = "R1 reset again";
    rst = 1'b1;
    run(2);
    rst = 1'b0;
    run(3);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule